// File: doc/BRIEF.md
# Single-Clock Byte-Lane FIFO with Arbitrary Depth

This block is a first-in first-out buffer for 32-bit words in which writes and reads share one clock. Its capacity is a parameter that may be any whole number of at least two, not only a power of two (3600, for instance). Words are held in an inferred dual-port memory, split into four 8-bit lanes that share one write address and one read address. A write pointer and a read pointer count in plain binary and return to zero after they pass the last slot. A separate occupancy counter tells a full buffer from an empty one when the two pointers are equal.

A producer offers a word with `push_i` and watches `at_capacity_o`. A consumer asks for a word with `pop_i` and watches `drained_o`. The word appears on `pop_data_o` one clock after the request is accepted. `near_full_o` rises once the occupancy reaches a threshold set by a parameter, so a producer can throttle early. Holding `rst_ni` low at a rising edge empties the buffer.

Top module: `lfifo_top`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the buffer empties. After that edge `drained_o`=1, `at_capacity_o`=0, `near_full_o`=0 and `pop_data_o`=0.
- R2: Words are read out in the order they were written, with all four byte lanes intact. The word for an accepted pop appears on `pop_data_o` after the same rising edge that accepts the pop, and it stays there until the next accepted pop.
- R3: `at_capacity_o` is 1 exactly when the buffer holds DEPTH words. A push while it is 1 stores nothing and leaves the occupancy unchanged.
- R4: A pop while `drained_o` is 1 is ignored. `pop_data_o` keeps its previous value and `drained_o` stays 1.
- R5: The pointers wrap to slot 0 after slot DEPTH-1, for a DEPTH that is not a power of two. Order is kept across many laps of the memory.
- R6: A push and a pop in the same cycle, when the buffer is neither empty nor full, leave the occupancy and the flags unchanged.
- R7: `near_full_o` is 1 exactly when the occupancy is at least AF_LEVEL.
- R8: A push and a pop in the same cycle on a full buffer accept only the pop. The same pair on an empty buffer accepts only the push, and `pop_data_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for both sides |
| rst_ni | input | 1 | Synchronous active-low clear |
| push_i | input | 1 | Write request |
| push_data_i | input | 32 | Word to store |
| pop_i | input | 1 | Read request |
| pop_data_o | output | 32 | Registered read word |
| at_capacity_o | output | 1 | Buffer holds DEPTH words |
| drained_o | output | 1 | Buffer holds no words |
| near_full_o | output | 1 | Occupancy at or above AF_LEVEL |

## Verification
A push and a pop can land in the same cycle. The occupancy then depends on whether the buffer was empty, full or in between. The bench drives both requests together in each of these three states. It judges the outcome from the flags and from the words later read out. In the middle state the flags must not move. On a full buffer the refused word must never appear during the drain that follows. On an empty buffer the read word must keep its old value while the new word becomes readable.

// File: rtl/lfifo_pkg.sv
// Shared definitions for the byte-lane FIFO.
// Assumes: the data width is a whole multiple of the lane width.
package lfifo_pkg;
    localparam int LANE_W = 8;

    // Accepted operation in one cycle; bit 1 = push accepted, bit 0 = pop accepted.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } lfifo_op_e;
endpackage

// File: rtl/lfifo_ptr.sv
// Binary slot pointer that steps by one on adv_i and wraps to 0 after DEPTH-1.
// Assumes: DEPTH >= 2; AW is wide enough to hold DEPTH-1.
module lfifo_ptr #(
    parameter int DEPTH = 12,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Step the pointer, folding back to slot zero past the last slot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            ptr_o <= '0;
        else if (adv_i)
            ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end

    AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, ptr_o} < (AW + 1)'(DEPTH)); // R5
    AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ptr_o == LAST) |=> (ptr_o == '0)); // R5
    AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && !adv_i) |=> $stable(ptr_o)); // R3
endmodule

// File: rtl/lfifo_lane.sv
// One byte lane of storage: a simple dual-port memory with a registered read.
// Assumes: a read and a write never target the same slot in one cycle
// (the control logic guarantees it), so no bypass is built.
module lfifo_lane #(
    parameter int DEPTH = 12,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wbyte_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rbyte_o
);
    logic [W-1:0] store_q [DEPTH];

    // Write port: store the lane byte at the write slot.
    always_ff @(posedge clk_i) begin
        if (we_i)
            store_q[waddr_i] <= wbyte_i;
    end

    // Read port: register the byte at the read slot on an accepted pop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            rbyte_o <= '0;
        else if (re_i)
            rbyte_o <= store_q[raddr_i];
    end
endmodule

// File: rtl/lfifo_ctrl.sv
// Occupancy counter and status flags; decides which requests are accepted.
// Assumes: AF_LEVEL lies in 1..DEPTH.
module lfifo_ctrl
    import lfifo_pkg::*;
#(
    parameter int DEPTH    = 12,
    parameter int AF_LEVEL = 9,
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  logic pop_i,
    output logic push_ok_o,
    output logic pop_ok_o,
    output logic full_o,
    output logic empty_o,
    output logic near_o
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);
    localparam logic [CW-1:0] THR = CW'(AF_LEVEL);

    logic [CW-1:0] level_q;
    lfifo_op_e     op;

    // Flags decoded from the held occupancy.
    always_comb begin
        full_o  = (level_q == CAP);
        empty_o = (level_q == '0);
        near_o  = (level_q >= THR);
    end

    // Accept a request only when the buffer can honour it.
    always_comb begin
        push_ok_o = push_i && !full_o;
        pop_ok_o  = pop_i && !empty_o;
        op        = lfifo_op_e'({push_ok_o, pop_ok_o});
    end

    // Track the number of stored words.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            level_q <= '0;
        else begin
            case (op)
                OP_PUSH: level_q <= level_q + 1'b1;
                OP_POP:  level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_q <= CAP); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !pop_i) |=> full_o); // R3
    AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (empty_o && !push_i) |=> empty_o); // R4
    AST_BOTH_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i && !full_o && !empty_o) |=> $stable(level_q)); // R6
    AST_FULL_POP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i && full_o) |=> (!full_o && !empty_o)); // R8
    AST_FLAGS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full_o && empty_o)); // R1
endmodule

// File: rtl/lfifo_top.sv
// Single-clock FIFO of DEPTH words (any DEPTH >= 2), stored as parallel byte lanes
// that share the write and read slot addresses. Read data is registered.
// Assumes: DATA_W is a multiple of the lane width.
module lfifo_top
    import lfifo_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 12,
    parameter int AF_LEVEL = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              at_capacity_o,
    output logic              drained_o,
    output logic              near_full_o
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          push_ok, pop_ok;
    logic [AW-1:0] wslot, rslot;

    lfifo_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .CW(CW)) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
        .push_ok_o(push_ok), .pop_ok_o(pop_ok),
        .full_o(at_capacity_o), .empty_o(drained_o), .near_o(near_full_o)
    );

    lfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(push_ok), .ptr_o(wslot)
    );

    lfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(pop_ok), .ptr_o(rslot)
    );

    // One storage lane per byte of the word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lfifo_lane #(.DEPTH(DEPTH), .AW(AW), .W(LANE_W)) u_lane (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .we_i(push_ok), .waddr_i(wslot), .wbyte_i(push_data_i[g*LANE_W +: LANE_W]),
            .re_i(pop_ok), .raddr_i(rslot), .rbyte_o(pop_data_o[g*LANE_W +: LANE_W])
        );
    end

    AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pop_i || drained_o) |=> $stable(pop_data_o)); // R4
    AST_SLOTS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!drained_o && !at_capacity_o) |-> (wslot != rslot)); // R5
    AST_SLOTS_MEET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drained_o || at_capacity_o) |-> (wslot == rslot)); // R3
endmodule

// File: tb/sim_lfifo_top.sv
module sim_lfifo_top;
    localparam int DEPTH = 12;
    localparam int AF    = 9;
    localparam int NV    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        full, empty, near;
    int          checks = 0, fails = 0, cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lfifo_top #(.DATA_W(32), .DEPTH(DEPTH), .AF_LEVEL(AF)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(wdata),
        .pop_i(pop), .pop_data_o(rdata), .at_capacity_o(full),
        .drained_o(empty), .near_full_o(near)
    );

    // Vector: push, pop, data, expected empty, expected full, expected read word.
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R4 pop on empty
        {1'b1, 1'b0, 32'h1122_3344, 1'b0, 1'b0, 32'h0000_0000}, // R2
        {1'b1, 1'b0, 32'hA5C3_0F96, 1'b0, 1'b0, 32'h0000_0000}, // R2
        {1'b1, 1'b1, 32'h00FF_00FF, 1'b0, 1'b0, 32'h1122_3344}, // R6
        {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 32'hA5C3_0F96}, // R2
        {1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h00FF_00FF}, // R6
        {1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'hDEAD_BEEF}, // R2
        {1'b1, 1'b1, 32'h8000_0001, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R8 both on empty
        {1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'h8000_0001}, // R8
        {1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'h8000_0001}  // R4
    };

    function automatic logic [31:0] fill_word(int i);
        return (32'h0101_0101 * (i + 1)) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [31:0] lap_word(int k);
        return (32'h0103_0507 * k) + 32'h1020_3040;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic p, logic q, logic [31:0] d);
        @(negedge clk);
        push = p; pop = q; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 near", 32'(near), 32'd0);
        chk("R1 rdata", rdata, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][67], VEC[i][66], VEC[i][65:34]);
            chk($sformatf("R2/R4/R6/R8 vec%0d empty", i), 32'(empty), 32'(VEC[i][33]));
            chk($sformatf("R3 vec%0d full", i), 32'(full), 32'(VEC[i][32]));
            chk($sformatf("R2 vec%0d rdata", i), rdata, VEC[i][31:0]);
        end

        // R3/R7: fill to capacity
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, fill_word(i));
            chk($sformatf("R7 near at %0d", i + 1), 32'(near), 32'((i + 1) >= AF));
            chk($sformatf("R3 full at %0d", i + 1), 32'(full), 32'((i + 1) == DEPTH));
        end
        step(1'b1, 1'b0, 32'h0000_0BAD);
        chk("R3 push while full keeps full", 32'(full), 32'd1);
        chk("R3 push while full keeps rdata", rdata, 32'h8000_0001);
        step(1'b1, 1'b1, 32'h0000_0BAD);
        chk("R8 both on full clears full", 32'(full), 32'd0);
        chk("R8 both on full reads oldest", rdata, fill_word(0));
        for (int i = 1; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 32'h0);
            chk($sformatf("R2 drain word %0d", i), rdata, fill_word(i));
        end
        chk("R3 refused words not stored", 32'(empty), 32'd1);

        // R5: many laps with words in flight
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, lap_word(k));
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 1'b1, lap_word(k + 5));
            chk($sformatf("R5 lap word %0d", k), rdata, lap_word(k));
        end
        chk("R6 level held across laps", 32'(near), 32'd0);
        for (int k = 40; k < 45; k++) begin
            step(1'b0, 1'b1, 32'h0);
            chk($sformatf("R5 tail word %0d", k), rdata, lap_word(k));
        end
        chk("R5 empty after laps", 32'(empty), 32'd1);

        // R1: clear while holding data
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, lap_word(100 + k));
        @(negedge clk);
        push = 1'b0; pop = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 clear empty", 32'(empty), 32'd1);
        chk("R1 clear full", 32'(full), 32'd0);
        chk("R1 clear rdata", rdata, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 1'b1, 32'h0);
        chk("R4 pop after clear ignored", rdata, 32'h0);
        chk("R4 still empty", 32'(empty), 32'd1);

        done = 1'b1;
        finish_run();
    end
endmodule